// File: doc/BRIEF.md
# Regulator Start-Up and Soft-Start Sequencer

This block is the digital control sequencer of a voltage regulator. It leaves its off state when the supply-good flag reports that the input supply is above the undervoltage threshold. It then runs a fixed initialization in four steps. First it pulls the external enable line low. Next it turns on the reference. It then latches the strap pins and loads the register defaults. After that it releases the enable line and opens the register port. From then on the enable input controls the regulator. While enable is low the registers can be read and written, but the converter stays idle. While enable is high, and after a short fixed delay, the block produces an 8-bit reference code for the DAC. That code climbs one LSB at a time from zero to the programmed setpoint over a selectable soft-start time.

The setpoint, output range and ramp-time selection are frozen when the ramp begins. Writes made during the ramp change the register contents but not the ramp in progress. Once the ramp has reached its target, the code follows any newer setpoint up or down at the live step rate. The light-load mode permission is forced on for the whole ramp. The ramp always starts from code zero, so a prebiased output sees only the part of the ramp above its own voltage.

Top module: `vreg_start_seq`

## Requirements
- R1: While `uvlo_ok` is low, `en_pd`, `ref_en`, `bus_en`, `ss_ramp` and `ss_done` are 0 and `ref_code` is 0. The first rising edge that samples `uvlo_ok` high starts initialization.
- R2: Initialization has four steps of INIT_STEP_CYC cycles each, in this order: pull-down (`en_pd`=1), reference on (`ref_en` rises), strap latch (`strap_q` takes `strap_in` at the end of this step), and default load. `en_pd` rises on the first edge, and `ref_en` rises INIT_STEP_CYC edges later and stays high until the supply flag drops.
- R3: On the edge that ends initialization, `bus_en` rises and `en_pd` falls. This happens 4*INIT_STEP_CYC+1 edges after the edge that sampled `uvlo_ok` high.
- R4: Register map: address 0 holds the setpoint (8 bits). Address 1 is the control register, with range in bits [1:0], ramp time in [3:2] and force-PWM in bit 4. Other addresses read 0. Writes take effect only while `bus_en` is 1. A read returns its data on `reg_rdata` one cycle after `reg_re`, and returns 0 while `bus_en` is 0. The defaults are: setpoint DEF_SP_HI if the latched strap bit 0 is 1, otherwise DEF_SP_LO; control 0x08.
- R5: While `en_in` is low after initialization, the registers stay accessible and `ss_ramp` and `ref_code` stay 0.
- R6: With `en_in` high, `ss_ramp` rises on the (EN_DLY_CYC+1)-th rising edge after `en_in` is first sampled high. The code starts at 0 on every ramp and only ever steps by +1 during the ramp.
- R7: The ramp-time field uses 00=500 µs, 01=770 µs, 10=1 ms and 11=2 ms. The step interval is floor(CLK_HZ·T/10^6/256) cycles, with a minimum of 1. A ramp to target N>0 lasts exactly N step intervals.
- R8: Writes to the setpoint, range or ramp time during the ramp do not alter its length or target. After the ramp, the code moves by ±1 per live step interval until it equals the current setpoint.
- R9: `pfm_allow` is 1 for the whole ramp whatever the force-PWM bit holds. Outside the ramp it is the inverse of force-PWM.
- R10: `ss_done` rises on the same edge on which `ref_code` first equals the captured target, and the ramp ends on that edge. With a target of 0 the ramp lasts one cycle. `ss_done` then stays high while the regulator remains on.
- R11: If `en_in` is sampled low, the next edge clears `ref_code`, `ss_done` and `ss_ramp` and keeps `bus_en`. If `uvlo_ok` is sampled low, the next edge also clears `bus_en` and `ref_en`, and the next rise repeats initialization with the defaults reloaded.
- R12: `ref_range` gives the range that was captured at ramp start for the duration of the ramp, and follows the live range value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok | input | 1 | Input supply above undervoltage threshold |
| en_in | input | 1 | Enable pin level, synchronous |
| strap_in | input | STRAP_W | Strap pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| en_pd | output | 1 | Enable-pin pull-down command (open-drain) |
| ref_en | output | 1 | Reference enable |
| bus_en | output | 1 | Register port enabled |
| strap_q | output | STRAP_W | Latched strap values |
| ref_code | output | DATA_W | Reference code to the DAC |
| ref_range | output | 2 | Output range in use |
| pfm_allow | output | 1 | Light-load mode permitted |
| ss_ramp | output | 1 | Soft-start ramp in progress |
| ss_done | output | 1 | Soft-start reached its target |

## Verification
The ramp is run once with each ramp-time code and a different target each time. Matching the measured ramp length against target times interval separates the four step rates and catches a wrong count or an off-by-one step. A ramp with a target of zero tests the immediate-done path. One ramp receives setpoint, range and ramp-time writes partway through. It must keep its length and range while running, then climb at the slow rate and finally step down to a lower setpoint. This separates captured values from live ones. Aborts by enable and by supply loss during a ramp show whether the clearing is immediate, whether the port is kept or dropped, and whether the defaults come back after reinitialization.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PD,
    ST_REF,
    ST_STRAP,
    ST_LOAD,
    ST_STBY,
    ST_DLY,
    ST_RAMP,
    ST_ON
  } seq_state_t;

  localparam int RT_W = 2;

  // soft-start duration in microseconds per ramp-time code
  function automatic int unsigned ramp_us(input int unsigned sel);
    case (sel)
      0:       return 500;
      1:       return 770;
      2:       return 1000;
      default: return 2000;
    endcase
  endfunction

  // cycles per code step so that 'levels' steps fit in the ramp time
  function automatic int unsigned step_len(input longint unsigned clk_hz,
                                           input int unsigned t_us,
                                           input int unsigned levels);
    longint unsigned cyc;
    cyc = (clk_hz * longint'(t_us)) / 64'd1000000;
    cyc = cyc / longint'(levels);
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/vreg_seq_fsm.sv
module vreg_seq_fsm
  import vreg_seq_pkg::*;
#(
  parameter int unsigned INIT_STEP_CYC = 4,
  parameter int unsigned EN_DLY_CYC    = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uvlo_ok,
  input  logic       en_in,
  input  logic       ramp_hit,
  output seq_state_t state_o,
  output logic       strap_take,
  output logic       load_defs,
  output logic       run_ok,
  output logic       hold_cap
);

  localparam int unsigned CNT_MAX = (INIT_STEP_CYC > EN_DLY_CYC) ? INIT_STEP_CYC : EN_DLY_CYC;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_STEP_CYC - 1);
  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(EN_DLY_CYC - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step_end;

  assign step_end = (cnt_q == INIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !uvlo_ok) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_q <= ST_PD;
          cnt_q   <= '0;
        end
        ST_PD, ST_REF, ST_STRAP, ST_LOAD: begin
          if (step_end) begin
            cnt_q <= '0;
            case (state_q)
              ST_PD:    state_q <= ST_REF;
              ST_REF:   state_q <= ST_STRAP;
              ST_STRAP: state_q <= ST_LOAD;
              default:  state_q <= ST_STBY;
            endcase
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_STBY: begin
          cnt_q <= '0;
          if (en_in) state_q <= ST_DLY;
        end
        ST_DLY: begin
          if (!en_in) begin
            state_q <= ST_STBY;
            cnt_q   <= '0;
          end else if (cnt_q == DLY_LAST) begin
            state_q <= ST_RAMP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RAMP: begin
          if (!en_in)        state_q <= ST_STBY;
          else if (ramp_hit) state_q <= ST_ON;
        end
        ST_ON: begin
          if (!en_in) state_q <= ST_STBY;
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign state_o    = state_q;
  assign strap_take = uvlo_ok && (state_q == ST_STRAP) && step_end;
  assign load_defs  = uvlo_ok && (state_q == ST_LOAD) && step_end;
  assign run_ok     = uvlo_ok && en_in && ((state_q == ST_RAMP) || (state_q == ST_ON));
  assign hold_cap   = (state_q == ST_RAMP);

  AST_UVLO_TO_OFF: assert property (@(posedge clk) disable iff (rst)
    !uvlo_ok |=> (state_q == ST_OFF)); // R11
  AST_REF_AFTER_PD: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_REF) && ($past(state_q) != ST_REF)) |-> ($past(state_q) == ST_PD)); // R2
  AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_STBY) && ($past(state_q) != ST_STBY)) |-> (($past(state_q) == ST_LOAD) || !$past(en_in))); // R5
  AST_RAMP_FROM_DLY: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RAMP) && ($past(state_q) != ST_RAMP)) |-> ($past(state_q) == ST_DLY)); // R6

endmodule

// File: rtl/vreg_seq_regs.sv
module vreg_seq_regs
  import vreg_seq_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 2,
  parameter int unsigned DEF_SP_LO = 32,
  parameter int unsigned DEF_SP_HI = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en_i,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              load_i,
  input  logic              strap_sel_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fpwm_o,
  output logic [DATA_W-1:0] cap_sp_o,
  output logic [1:0]        cap_range_o,
  output logic [RT_W-1:0]   cap_rt_o
);

  localparam logic [ADDR_W-1:0] ADR_SP  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CTL = ADDR_W'(1);
  localparam int RNG_LO  = 0;
  localparam int RT_LO   = 2;
  localparam int FPWM_B  = 4;
  localparam logic [RT_W-1:0]   RT_DEF = 2'b10;
  localparam logic [DATA_W-1:0] SP_LO  = DATA_W'(DEF_SP_LO);
  localparam logic [DATA_W-1:0] SP_HI  = DATA_W'(DEF_SP_HI);

  logic [DATA_W-1:0] sp_q, cap_sp_q, rdata_q;
  logic [1:0]        range_q, cap_range_q;
  logic [RT_W-1:0]   rt_q, cap_rt_q;
  logic              fpwm_q;
  logic [DATA_W-1:0] ctl_view;

  assign ctl_view = {{(DATA_W-5){1'b0}}, fpwm_q, rt_q, range_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= SP_LO;
      range_q <= 2'b00;
      rt_q    <= RT_DEF;
      fpwm_q  <= 1'b0;
    end else if (load_i) begin
      sp_q    <= strap_sel_i ? SP_HI : SP_LO;
      range_q <= 2'b00;
      rt_q    <= RT_DEF;
      fpwm_q  <= 1'b0;
    end else if (bus_en_i && reg_we) begin
      if (reg_addr == ADR_SP) sp_q <= reg_wdata;
      if (reg_addr == ADR_CTL) begin
        range_q <= reg_wdata[RNG_LO +: 2];
        rt_q    <= reg_wdata[RT_LO +: RT_W];
        fpwm_q  <= reg_wdata[FPWM_B];
      end
    end
  end

  // captured copy tracks the live registers except while the ramp runs
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sp_q    <= SP_LO;
      cap_range_q <= 2'b00;
      cap_rt_q    <= RT_DEF;
    end else if (!hold_i) begin
      cap_sp_q    <= sp_q;
      cap_range_q <= range_q;
      cap_rt_q    <= rt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_en_i && reg_re) begin
      if (reg_addr == ADR_SP)       rdata_q <= sp_q;
      else if (reg_addr == ADR_CTL) rdata_q <= ctl_view;
      else                          rdata_q <= '0;
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o     = rdata_q;
  assign fpwm_o      = fpwm_q;
  assign cap_sp_o    = cap_sp_q;
  assign cap_range_o = cap_range_q;
  assign cap_rt_o    = cap_rt_q;

  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(hold_i) |-> ($stable(cap_sp_q) && $stable(cap_rt_q) && $stable(cap_range_q))); // R8
  AST_BUS_GATED: assert property (@(posedge clk) disable iff (rst)
    (!bus_en_i && !load_i) |=> ($stable(sp_q) && $stable(rt_q) && $stable(fpwm_q))); // R4

endmodule

// File: rtl/vreg_seq_ramp.sv
module vreg_seq_ramp
  import vreg_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100000000,
  parameter int              CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_ok_i,
  input  logic              in_ramp_i,
  input  logic [CODE_W-1:0] tgt_i,
  input  logic [RT_W-1:0]   rt_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              done_o,
  output logic              hit_o
);

  localparam int unsigned LEVELS = 1 << CODE_W;
  localparam int unsigned STEP0  = step_len(CLK_HZ, ramp_us(0), LEVELS);
  localparam int unsigned STEP1  = step_len(CLK_HZ, ramp_us(1), LEVELS);
  localparam int unsigned STEP2  = step_len(CLK_HZ, ramp_us(2), LEVELS);
  localparam int unsigned STEP3  = step_len(CLK_HZ, ramp_us(3), LEVELS);
  localparam int CNT_W = $clog2(STEP3 + 1);

  logic [CNT_W-1:0]  step_cnt, step_sel;
  logic [CODE_W-1:0] ref_q, ref_inc;
  logic              done_q, tick;

  always_comb begin
    case (rt_i)
      2'd0:    step_sel = CNT_W'(STEP0);
      2'd1:    step_sel = CNT_W'(STEP1);
      2'd2:    step_sel = CNT_W'(STEP2);
      default: step_sel = CNT_W'(STEP3);
    endcase
  end

  assign tick    = (step_cnt >= (step_sel - CNT_W'(1)));
  assign ref_inc = ref_q + CODE_W'(1);
  assign hit_o   = run_ok_i && in_ramp_i &&
                   ((ref_q == tgt_i) || (tick && (ref_inc == tgt_i)));

  always_ff @(posedge clk) begin
    if (rst || !run_ok_i) begin
      ref_q    <= '0;
      step_cnt <= '0;
      done_q   <= 1'b0;
    end else begin
      step_cnt <= tick ? '0 : step_cnt + CNT_W'(1);
      if (in_ramp_i) begin
        if (hit_o) done_q <= 1'b1;
        if (tick && (ref_q != tgt_i)) ref_q <= ref_inc;
      end else begin
        done_q <= 1'b1;
        if (tick) begin
          if (ref_q < tgt_i)      ref_q <= ref_inc;
          else if (ref_q > tgt_i) ref_q <= ref_q - CODE_W'(1);
        end
      end
    end
  end

  assign ref_o  = ref_q;
  assign done_o = done_q;

  AST_RAMP_MONO: assert property (@(posedge clk) disable iff (rst)
    (run_ok_i && in_ramp_i) |=> ((ref_q == $past(ref_q)) || (ref_q == $past(ref_inc)) || (ref_q == '0))); // R6
  AST_DONE_AT_TGT: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (ref_q == tgt_i)); // R10

endmodule

// File: rtl/vreg_start_seq.sv
module vreg_start_seq
  import vreg_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ        = 100000000,
  parameter int              DATA_W        = 8,
  parameter int              ADDR_W        = 2,
  parameter int              STRAP_W       = 3,
  parameter int unsigned     INIT_STEP_CYC = 4,
  parameter int unsigned     EN_DLY_CYC    = 64,
  parameter int unsigned     DEF_SP_LO     = 32,
  parameter int unsigned     DEF_SP_HI     = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               uvlo_ok,
  input  logic               en_in,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               en_pd,
  output logic               ref_en,
  output logic               bus_en,
  output logic [STRAP_W-1:0] strap_q,
  output logic [DATA_W-1:0]  ref_code,
  output logic [1:0]         ref_range,
  output logic               pfm_allow,
  output logic               ss_ramp,
  output logic               ss_done
);

  seq_state_t        state;
  logic              strap_take, load_defs, run_ok, hold_cap, ramp_hit, fpwm;
  logic [DATA_W-1:0] cap_sp;
  logic [RT_W-1:0]   cap_rt;
  logic [STRAP_W-1:0] strap_r;

  vreg_seq_fsm #(
    .INIT_STEP_CYC(INIT_STEP_CYC),
    .EN_DLY_CYC   (EN_DLY_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .uvlo_ok   (uvlo_ok),
    .en_in     (en_in),
    .ramp_hit  (ramp_hit),
    .state_o   (state),
    .strap_take(strap_take),
    .load_defs (load_defs),
    .run_ok    (run_ok),
    .hold_cap  (hold_cap)
  );

  always_ff @(posedge clk) begin
    if (rst)             strap_r <= '0;
    else if (strap_take) strap_r <= strap_in;
  end

  vreg_seq_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .DEF_SP_LO(DEF_SP_LO),
    .DEF_SP_HI(DEF_SP_HI)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_en_i   (bus_en),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .load_i     (load_defs),
    .strap_sel_i(strap_r[0]),
    .hold_i     (hold_cap),
    .rdata_o    (reg_rdata),
    .fpwm_o     (fpwm),
    .cap_sp_o   (cap_sp),
    .cap_range_o(ref_range),
    .cap_rt_o   (cap_rt)
  );

  vreg_seq_ramp #(
    .CLK_HZ(CLK_HZ),
    .CODE_W(DATA_W)
  ) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .run_ok_i (run_ok),
    .in_ramp_i(state == ST_RAMP),
    .tgt_i    (cap_sp),
    .rt_i     (cap_rt),
    .ref_o    (ref_code),
    .done_o   (ss_done),
    .hit_o    (ramp_hit)
  );

  assign strap_q   = strap_r;
  assign en_pd     = (state == ST_PD) || (state == ST_REF) || (state == ST_STRAP) || (state == ST_LOAD);
  assign ref_en    = (state != ST_OFF) && (state != ST_PD);
  assign bus_en    = (state == ST_STBY) || (state == ST_DLY) || (state == ST_RAMP) || (state == ST_ON);
  assign ss_ramp   = (state == ST_RAMP);
  assign pfm_allow = ss_ramp || !fpwm;

  AST_UVLO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !uvlo_ok |=> ((ref_code == '0) && !bus_en && !ref_en && !ss_done)); // R11
  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> ((ref_code == '0) && !ss_done && !ss_ramp)); // R11
  AST_PD_NOT_WITH_BUS: assert property (@(posedge clk) disable iff (rst)
    $fell(en_pd) |-> (bus_en || !uvlo_ok || !$past(uvlo_ok))); // R3

endmodule

// File: tb/test_vreg_start_seq.sv
module test_vreg_start_seq;

  localparam int DLY   = 8;
  localparam int ISTEP = 2;
  localparam int SP_LO = 32;
  localparam int SP_HI = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       uvlo_ok = 1'b0;
  logic       en_in = 1'b0;
  logic [2:0] strap_in = 3'b000;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata, ref_code;
  logic       en_pd, ref_en, bus_en, pfm_allow, ss_ramp, ss_done;
  logic [2:0] strap_q;
  logic [1:0] ref_range;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vreg_start_seq #(
    .CLK_HZ(2560000), .DATA_W(8), .ADDR_W(2), .STRAP_W(3),
    .INIT_STEP_CYC(ISTEP), .EN_DLY_CYC(DLY), .DEF_SP_LO(SP_LO), .DEF_SP_HI(SP_HI)
  ) i_vreg_start_seq (
    .clk(clk), .rst(rst), .uvlo_ok(uvlo_ok), .en_in(en_in), .strap_in(strap_in),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .en_pd(en_pd), .ref_en(ref_en), .bus_en(bus_en),
    .strap_q(strap_q), .ref_code(ref_code), .ref_range(ref_range),
    .pfm_allow(pfm_allow), .ss_ramp(ss_ramp), .ss_done(ss_done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] ctl(input int fpwm, input int rt, input int rng);
    return 8'((fpwm << 4) | (rt << 2) | rng);
  endfunction

  // raises en, measures delay and ramp, returns with ramp finished (or timed out)
  task automatic run_ramp(output int dly, output int len, output int bad_steps, output int pfm_low);
    int prev;
    dly = 0; len = 0; bad_steps = 0; pfm_low = 0;
    en_in = 1'b1;
    do begin @(negedge clk); dly++; end while (!ss_ramp && dly < 200);
    prev = ref_code;
    while (ss_ramp && len < 20000) begin
      len++;
      if (!pfm_allow) pfm_low++;
      @(negedge clk);
      if (ref_code != prev) begin
        if (ref_code != prev + 1) bad_steps++;
        prev = ref_code;
      end
    end
  endtask

  task automatic t_off_state;
    cyc(5);
    chk("R1 en_pd off", en_pd, 0);
    chk("R1 ref_en off", ref_en, 0);
    chk("R1 bus_en off", bus_en, 0);
    chk("R1 ref_code off", ref_code, 0);
    chk("R1 ss_done off", ss_done, 0);
  endtask

  task automatic t_init(input logic [2:0] straps, input int exp_sp);
    int k_pd, k_ref, k_bus, k_pdlo;
    logic [7:0] v;
    k_pd = -1; k_ref = -1; k_bus = -1; k_pdlo = -1;
    strap_in = straps;
    uvlo_ok = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (en_pd && k_pd < 0) k_pd = k;
      if (ref_en && k_ref < 0) k_ref = k;
      if (bus_en && k_bus < 0) k_bus = k;
      if (!en_pd && k_pd > 0 && k_pdlo < 0) k_pdlo = k;
      reg_we = (k == 3); reg_addr = 2'd0; reg_wdata = 8'h77;
    end
    reg_we = 1'b0;
    chk("R2 pull-down first edge", k_pd, 1);
    chk("R2 ref_en after pd step", k_ref, 1 + ISTEP);
    chk("R3 bus_en edge", k_bus, 4 * ISTEP + 1);
    chk("R3 pd released with bus", k_pdlo, 4 * ISTEP + 1);
    chk("R2 strap latched", strap_q, straps);
    rd(2'd0, v);
    chk("R4 default setpoint, early write ignored", v, exp_sp);
    rd(2'd1, v);
    chk("R4 default control", v, 8'h08);
    rd(2'd2, v);
    chk("R4 unmapped address", v, 0);
  endtask

  task automatic t_standby;
    logic [7:0] v;
    int seen;
    seen = 0;
    wr(2'd0, 8'h11);
    rd(2'd0, v);
    chk("R5 write in standby", v, 8'h11);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ss_ramp || ref_code != 0) seen++;
    end
    chk("R5 idle while en low", seen, 0);
    chk("R9 pfm_allow with fpwm=0", pfm_allow, 1);
  endtask

  task automatic t_ramp(input int rt, input int sp, input int step);
    int dly, len, bs, pl, exp_len;
    wr(2'd1, ctl(0, rt, 0));
    wr(2'd0, 8'(sp));
    exp_len = (sp == 0) ? 1 : sp * step;
    run_ramp(dly, len, bs, pl);
    chk("R6 enable delay", dly, DLY + 1);
    chk($sformatf("R7 ramp length rt=%0d", rt), len, exp_len);
    chk("R6 unit steps", bs, 0);
    chk("R9 pfm forced", pl, 0);
    chk("R10 done at end", ss_done, 1);
    chk("R10 code at target", ref_code, sp);
    en_in = 1'b0;
    @(negedge clk);
    chk("R11 en low clears code", ref_code, 0);
    chk("R11 en low clears done", ss_done, 0);
    chk("R11 bus kept", bus_en, 1);
    cyc(2);
  endtask

  task automatic t_hold;
    int k, len, rng_bad;
    wr(2'd1, ctl(0, 1, 1));
    wr(2'd0, 8'd20);
    en_in = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!ss_ramp && k < 200);
    len = 0; rng_bad = 0;
    while (ss_ramp && len < 5000) begin
      len++;
      if (ref_range != 2'd1) rng_bad++;
      reg_we = (len == 10 || len == 11);
      reg_addr = (len == 10) ? 2'd0 : 2'd1;
      reg_wdata = (len == 10) ? 8'd30 : ctl(0, 3, 2);
      @(negedge clk);
    end
    reg_we = 1'b0;
    chk("R8 ramp length unchanged by writes", len, 20 * 7);
    chk("R12 range frozen in ramp", rng_bad, 0);
    chk("R8 first target reached", ref_code, 20);
    cyc(2);
    chk("R12 live range after ramp", ref_range, 2);
    cyc(146);
    chk("R8 slow second ramp midway", (ref_code >= 26 && ref_code <= 28), 1);
    cyc(62);
    chk("R8 second ramp reaches new setpoint", ref_code, 30);
    chk("R10 done held while on", ss_done, 1);
    wr(2'd0, 8'd28);
    cyc(70);
    chk("R8 steps down to lower setpoint", ref_code, 28);
    en_in = 1'b0;
    cyc(2);
  endtask

  task automatic t_pfm;
    int dly, len, bs, pl;
    wr(2'd1, ctl(1, 0, 0));
    wr(2'd0, 8'd4);
    chk("R9 fpwm blocks light load", pfm_allow, 0);
    run_ramp(dly, len, bs, pl);
    chk("R9 forced despite fpwm", pl, 0);
    chk("R7 short ramp", len, 20);
    chk("R9 released after ramp", pfm_allow, 0);
    en_in = 1'b0;
    cyc(2);
  endtask

  task automatic t_abort_en;
    int dly, len, bs, pl;
    wr(2'd1, ctl(0, 2, 0));
    wr(2'd0, 8'd40);
    en_in = 1'b1;
    cyc(DLY + 60);
    chk("R11 ramp underway", ss_ramp, 1);
    en_in = 1'b0;
    @(negedge clk);
    chk("R11 abort clears code", ref_code, 0);
    chk("R11 abort ends ramp", ss_ramp, 0);
    cyc(3);
    run_ramp(dly, len, bs, pl);
    chk("R6 restart from zero full length", len, 400);
    chk("R6 restart unit steps", bs, 0);
  endtask

  task automatic t_abort_uvlo;
    uvlo_ok = 1'b0;
    @(negedge clk);
    chk("R11 uvlo clears bus", bus_en, 0);
    chk("R11 uvlo clears ref_en", ref_en, 0);
    chk("R11 uvlo clears code", ref_code, 0);
    chk("R1 no pull-down in off", en_pd, 0);
    en_in = 1'b0;
    cyc(3);
    t_init(3'b010, SP_LO);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_off_state();
    t_init(3'b101, SP_HI);
    t_standby();
    t_ramp(0, 5, 5);
    t_ramp(1, 9, 7);
    t_ramp(2, 12, 10);
    t_ramp(3, 6, 20);
    t_ramp(2, 0, 10);
    t_hold();
    t_pfm();
    t_abort_en();
    t_abort_uvlo();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule